// File: doc/BRIEF.md
# LPC I/O Target with Host/Firmware Mailboxes

This block sits on the peripheral side of an LPC bus and answers host I/O read and I/O write cycles. It gives the host four mailbox channels. Each channel is placed at its own 16-bit I/O base. At that base the host writes a byte toward firmware, reads a byte prepared by firmware, and reads a status byte whose two flags show which direction still holds unread data. The third channel also has a sixteen-byte scratch window that both sides can read and write.

Firmware reaches the same storage through a simple synchronous register port. Through this port it can also move any channel's base address. Cycles of any other type are ignored. Addresses that no channel claims get no response, so the host's own timeout ends those cycles.

Top module: `lpc_mailbox_target`

## Requirements
- R1: After reset `nib_oe` is 0, every channel's status byte reads 0, and each base reads its reset value (channel 0 = 0x0CA0, 1 = 0x0CA8, 2 = 0x0D00, 3 = 0x0CB0).
- R2: An I/O write cycle is START nibble 0x0 with `frame_n` low, then cycle type 0x2, then four address nibbles most significant first, then two data nibbles low first, then two turnaround clocks. The target then drives 0x0 for exactly one clock and releases the bus.
- R3: An I/O read cycle uses cycle type 0x0, then four address nibbles and two turnaround clocks. The target then drives 0x0 for one clock, then the low and then the high data nibble, and releases the bus.
- R4: `nib_oe` is high only in the acknowledge and read-data clocks, and never for more than three clocks in a row.
- R5: A cycle type other than 0x0 or 0x2 produces no drive and changes no stored state.
- R6: A cycle whose address no channel claims produces no drive and changes no stored state.
- R7: A host write to base+0 stores the byte for firmware and sets status bit 1. A firmware read of local offset 0 returns that byte and clears bit 1.
- R8: A firmware write to local offset 1 sets status bit 0. A host read of base+0 returns that byte and clears bit 0. A host read of base+1 returns the status byte.
- R9: Firmware offsets 3 and 4 hold the base's low and high byte, and decoding follows a new value at once. When two channels claim one address, the lower-numbered channel takes it.
- R10: Channel 2 maps sixteen shared bytes at host base+16..base+31 and at firmware offsets 16..31. No other channel answers at base+16.
- R11: `fw_rdata` takes its new value on the clock edge that samples a read request, and holds that value until the next read.
- R12: A host write to base+1 changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; all logic runs on its rising edge |
| bus_rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Low marks a cycle start |
| nib_in | input | 4 | Nibble sampled from the bus |
| nib_out | output | 4 | Nibble driven onto the bus |
| nib_oe | output | 1 | Enables `nib_out` onto the bus |
| fw_sel | input | 1 | Firmware access request |
| fw_wr | input | 1 | 1 = write, 0 = read |
| fw_addr | input | 7 | [6:5] channel, [4:0] offset |
| fw_wdata | input | 8 | Firmware write byte |
| fw_rdata | output | 8 | Registered firmware read byte |

## Verification
The assertions check the bus-side rules on every clock. The acknowledge nibble is always zero, the drive enable stays inside the response phases and its burst length, and a bad cycle type or a missed address always returns to idle. They also check the flag handshakes: a host byte sets the input flag, a firmware read clears it, and the output flag works the same way in the other direction. Some results can only be seen by replaying whole cycles against a model: the order of data nibbles, the priority between overlapping bases, base reprogramming, the shared window, and the fact that ignored cycles leave the stored bytes as they were. The bench scenarios cover these.

// File: rtl/lpc_mbx_pkg.sv
package lpc_mbx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTYPE,
    PH_ADDR,
    PH_WDATA,
    PH_TAR_IN,
    PH_SYNC,
    PH_RDATA,
    PH_TAR_OUT
  } lpc_phase_e;

  localparam logic [3:0] NIB_START   = 4'h0;
  localparam logic [3:0] NIB_IORD    = 4'h0;
  localparam logic [3:0] NIB_IOWR    = 4'h2;
  localparam logic [3:0] NIB_ACK     = 4'h0;
  localparam logic [3:0] NIB_IDLE    = 4'hF;

  // host-side offsets from a channel base
  localparam int HOFF_DATA = 0;
  localparam int HOFF_STS  = 1;
  localparam int HOFF_SPAN = 2;

  // firmware-side offsets inside a channel
  localparam int FOFF_IDR = 0;
  localparam int FOFF_ODR = 1;
  localparam int FOFF_STS = 2;
  localparam int FOFF_BLO = 3;
  localparam int FOFF_BHI = 4;

  // status bit positions
  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;

endpackage

// File: rtl/lpc_cycle_fsm.sv
module lpc_cycle_fsm
  import lpc_mbx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        nib_in,
  output logic [3:0]        nib_out,
  output logic              nib_oe,
  output logic [AW-1:0]     cand_addr,
  output logic              addr_done,
  input  logic              hit,
  output logic              host_we,
  output logic              host_re,
  output logic [BYTE_W-1:0] host_wdata,
  input  logic [BYTE_W-1:0] host_rdata
);

  localparam int ADDR_NIBS = AW / 4;
  localparam int DATA_NIBS = BYTE_W / 4;
  localparam int CNT_W     = $clog2(ADDR_NIBS);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_NIBS - 1);
  localparam logic [CNT_W-1:0] LAST_T = CNT_W'(1);

  lpc_phase_e        ph, ph_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              is_wr, is_wr_n;
  logic [AW-5:0]     addr_q, addr_n;
  logic [3:0]        wlo, wlo_n;
  logic [BYTE_W-1:0] rd_q;

  assign cand_addr  = {addr_q, nib_in};
  assign addr_done  = frame_n && (ph == PH_ADDR) && (cnt == LAST_A);
  assign host_wdata = {nib_in, wlo};

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt;
    is_wr_n = is_wr;
    addr_n  = addr_q;
    wlo_n   = wlo;
    host_we = 1'b0;
    host_re = 1'b0;
    if (!frame_n) begin
      ph_n  = (nib_in == NIB_START) ? PH_CTYPE : PH_IDLE;
      cnt_n = '0;
    end else begin
      case (ph)
        PH_IDLE: ;
        PH_CTYPE: begin
          cnt_n = '0;
          if (nib_in == NIB_IORD) begin
            ph_n    = PH_ADDR;
            is_wr_n = 1'b0;
          end else if (nib_in == NIB_IOWR) begin
            ph_n    = PH_ADDR;
            is_wr_n = 1'b1;
          end else begin
            ph_n = PH_IDLE;
          end
        end
        PH_ADDR: begin
          addr_n = cand_addr[AW-5:0];
          if (cnt == LAST_A) begin
            cnt_n = '0;
            if (!hit)       ph_n = PH_IDLE;
            else if (is_wr) ph_n = PH_WDATA;
            else            ph_n = PH_TAR_IN;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_WDATA: begin
          if (cnt == LAST_D) begin
            host_we = 1'b1;
            cnt_n   = '0;
            ph_n    = PH_TAR_IN;
          end else begin
            wlo_n = nib_in;
            cnt_n = cnt + 1'b1;
          end
        end
        PH_TAR_IN: begin
          if (cnt == LAST_T) begin
            cnt_n   = '0;
            ph_n    = PH_SYNC;
            host_re = !is_wr;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_SYNC: begin
          cnt_n = '0;
          ph_n  = is_wr ? PH_TAR_OUT : PH_RDATA;
        end
        PH_RDATA: begin
          if (cnt == LAST_D) begin
            cnt_n = '0;
            ph_n  = PH_TAR_OUT;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        PH_TAR_OUT: begin
          if (cnt == LAST_T) begin
            cnt_n = '0;
            ph_n  = PH_IDLE;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      wlo     <= '0;
      rd_q    <= '0;
      nib_oe  <= 1'b0;
      nib_out <= NIB_IDLE;
    end else begin
      ph     <= ph_n;
      cnt    <= cnt_n;
      is_wr  <= is_wr_n;
      addr_q <= addr_n;
      wlo    <= wlo_n;
      if (host_re) rd_q <= host_rdata;
      nib_oe <= (ph_n == PH_SYNC) || (ph_n == PH_RDATA);
      if (ph_n == PH_SYNC)
        nib_out <= NIB_ACK;
      else if (ph_n == PH_RDATA)
        nib_out <= (cnt_n == '0) ? rd_q[3:0] : rd_q[7:4];
      else
        nib_out <= NIB_IDLE;
    end
  end

  AST_OE_IN_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    nib_oe |-> (ph == PH_SYNC || ph == PH_RDATA)); // R4

  AST_DRIVE_BURST: assert property (@(posedge clk) disable iff (rst)
    (nib_oe && $past(nib_oe) && $past(nib_oe, 2)) |=> !nib_oe); // R4

  AST_ACK_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SYNC) |-> (nib_oe && nib_out == NIB_ACK)); // R2

  AST_BAD_TYPE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (frame_n && ph == PH_CTYPE && nib_in != NIB_IORD && nib_in != NIB_IOWR)
      |=> (ph == PH_IDLE && !nib_oe)); // R5

  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (addr_done && !hit) |=> (ph == PH_IDLE && !nib_oe)); // R6

endmodule

// File: rtl/lpc_addr_decode.sv
module lpc_addr_decode
  import lpc_mbx_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 16,
  parameter int EXT_DEPTH = 16,
  parameter int EXT_CH    = 2,
  localparam int CH_W     = $clog2(NCH),
  localparam int OFF_W    = $clog2(2 * EXT_DEPTH)
) (
  input  logic [AW-1:0]          addr,
  input  logic [NCH-1:0][AW-1:0] bases,
  output logic                   hit,
  output logic [CH_W-1:0]        hit_ch,
  output logic [OFF_W-1:0]       hit_off
);

  logic [NCH-1:0][AW-1:0] diff;
  logic [NCH-1:0]         match;

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    assign diff[k] = addr - bases[k];
    if (k == EXT_CH) begin : g_ext
      assign match[k] = (diff[k] < AW'(HOFF_SPAN)) ||
                        ((diff[k] >= AW'(EXT_DEPTH)) && (diff[k] < AW'(2 * EXT_DEPTH)));
    end else begin : g_base
      assign match[k] = (diff[k] < AW'(HOFF_SPAN));
    end
  end

  // lowest-numbered channel wins: scan from the top, last assignment sticks
  always_comb begin
    hit     = 1'b0;
    hit_ch  = '0;
    hit_off = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit     = 1'b1;
        hit_ch  = CH_W'(k);
        hit_off = diff[k][OFF_W-1:0];
      end
    end
  end

endmodule

// File: rtl/lpc_mbx_channel.sv
module lpc_mbx_channel
  import lpc_mbx_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            EXT_DEPTH = 16,
  parameter bit            HAS_EXT   = 1'b0,
  parameter logic [AW-1:0] BASE_RST  = '0,
  localparam int OFF_W = $clog2(2 * EXT_DEPTH),
  localparam int IDX_W = $clog2(EXT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [OFF_W-1:0]  h_off,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  input  logic              f_we,
  input  logic              f_re,
  input  logic [OFF_W-1:0]  f_off,
  input  logic [BYTE_W-1:0] f_wdata,
  output logic [BYTE_W-1:0] f_rdata,
  output logic [AW-1:0]     base
);

  logic [BYTE_W-1:0] idr, odr, sts;
  logic              ibf, obf;
  logic [BYTE_W-1:0] ext_h, ext_f;
  logic              h_ext, f_ext;

  logic h_data_wr, h_data_rd, f_idr_rd, f_odr_wr;
  assign h_data_wr = h_we && (h_off == OFF_W'(HOFF_DATA));
  assign h_data_rd = h_re && (h_off == OFF_W'(HOFF_DATA));
  assign f_idr_rd  = f_re && (f_off == OFF_W'(FOFF_IDR));
  assign f_odr_wr  = f_we && (f_off == OFF_W'(FOFF_ODR));

  always_ff @(posedge clk) begin
    if (rst) begin
      idr  <= '0;
      odr  <= '0;
      ibf  <= 1'b0;
      obf  <= 1'b0;
      base <= BASE_RST;
    end else begin
      if (h_data_wr) idr <= h_wdata;
      if (f_odr_wr)  odr <= f_wdata;
      if (f_we && f_off == OFF_W'(FOFF_BLO)) base[BYTE_W-1:0]  <= f_wdata;
      if (f_we && f_off == OFF_W'(FOFF_BHI)) base[AW-1:BYTE_W] <= f_wdata[AW-BYTE_W-1:0];
      // a set in the same clock as a clear wins
      if (h_data_wr)     ibf <= 1'b1;
      else if (f_idr_rd) ibf <= 1'b0;
      if (f_odr_wr)       obf <= 1'b1;
      else if (h_data_rd) obf <= 1'b0;
    end
  end

  always_comb begin
    sts          = '0;
    sts[STS_OBF] = obf;
    sts[STS_IBF] = ibf;
  end

  if (HAS_EXT) begin : g_ext
    logic [BYTE_W-1:0] mem [EXT_DEPTH];
    assign h_ext = h_off[OFF_W-1];
    assign f_ext = f_off[OFF_W-1];
    always_ff @(posedge clk) begin
      if (h_we && h_ext)      mem[h_off[IDX_W-1:0]] <= h_wdata;
      else if (f_we && f_ext) mem[f_off[IDX_W-1:0]] <= f_wdata;
    end
    assign ext_h = mem[h_off[IDX_W-1:0]];
    assign ext_f = mem[f_off[IDX_W-1:0]];
  end else begin : g_no_ext
    assign h_ext = 1'b0;
    assign f_ext = 1'b0;
    assign ext_h = '0;
    assign ext_f = '0;
  end

  always_comb begin
    if (h_ext)                              h_rdata = ext_h;
    else if (h_off == OFF_W'(HOFF_DATA))    h_rdata = odr;
    else if (h_off == OFF_W'(HOFF_STS))     h_rdata = sts;
    else                                    h_rdata = '0;
  end

  always_comb begin
    if (f_ext)                              f_rdata = ext_f;
    else if (f_off == OFF_W'(FOFF_IDR))     f_rdata = idr;
    else if (f_off == OFF_W'(FOFF_ODR))     f_rdata = odr;
    else if (f_off == OFF_W'(FOFF_STS))     f_rdata = sts;
    else if (f_off == OFF_W'(FOFF_BLO))     f_rdata = base[BYTE_W-1:0];
    else if (f_off == OFF_W'(FOFF_BHI))     f_rdata = BYTE_W'(base[AW-1:BYTE_W]);
    else                                    f_rdata = '0;
  end

  AST_IBF_SET: assert property (@(posedge clk) disable iff (rst)
    h_data_wr |=> ibf); // R7

  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (f_idr_rd && !h_data_wr) |=> !ibf); // R7

  AST_OBF_SET: assert property (@(posedge clk) disable iff (rst)
    f_odr_wr |=> obf); // R8

  AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (h_data_rd && !f_odr_wr) |=> !obf); // R8

  AST_STS_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
    (h_we && h_off == OFF_W'(HOFF_STS)) |=> $stable(idr)); // R12

endmodule

// File: rtl/lpc_mailbox_target.sv
module lpc_mailbox_target
  import lpc_mbx_pkg::*;
#(
  parameter int                NCH       = 4,
  parameter int                AW        = 16,
  parameter int                EXT_DEPTH = 16,
  parameter int                EXT_CH    = 2,
  parameter logic [NCH*AW-1:0] BASE_RST  = 64'h0CB0_0D00_0CA8_0CA0,
  localparam int CH_W  = $clog2(NCH),
  localparam int OFF_W = $clog2(2 * EXT_DEPTH),
  localparam int FA_W  = CH_W + OFF_W
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              frame_n,
  input  logic [3:0]        nib_in,
  output logic [3:0]        nib_out,
  output logic              nib_oe,
  input  logic              fw_sel,
  input  logic              fw_wr,
  input  logic [FA_W-1:0]   fw_addr,
  input  logic [BYTE_W-1:0] fw_wdata,
  output logic [BYTE_W-1:0] fw_rdata
);

  logic [AW-1:0]              cand_addr;
  logic                       addr_done, hit;
  logic [CH_W-1:0]            dec_ch, sel_ch_q;
  logic [OFF_W-1:0]           dec_off, sel_off_q;
  logic                       host_we, host_re;
  logic [BYTE_W-1:0]          host_wdata, host_rdata;
  logic [NCH-1:0][AW-1:0]     ch_base;
  logic [NCH-1:0][BYTE_W-1:0] ch_h_rdata, ch_f_rdata;
  logic [CH_W-1:0]            f_ch;
  logic [OFF_W-1:0]           f_off;

  assign f_ch  = fw_addr[FA_W-1:OFF_W];
  assign f_off = fw_addr[OFF_W-1:0];

  lpc_cycle_fsm #(.AW(AW)) u_fsm (
    .clk        (bus_clk),
    .rst        (bus_rst),
    .frame_n    (frame_n),
    .nib_in     (nib_in),
    .nib_out    (nib_out),
    .nib_oe     (nib_oe),
    .cand_addr  (cand_addr),
    .addr_done  (addr_done),
    .hit        (hit),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  lpc_addr_decode #(
    .NCH(NCH), .AW(AW), .EXT_DEPTH(EXT_DEPTH), .EXT_CH(EXT_CH)
  ) u_dec (
    .addr    (cand_addr),
    .bases   (ch_base),
    .hit     (hit),
    .hit_ch  (dec_ch),
    .hit_off (dec_off)
  );

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      sel_ch_q  <= '0;
      sel_off_q <= '0;
    end else if (addr_done && hit) begin
      sel_ch_q  <= dec_ch;
      sel_off_q <= dec_off;
    end
  end

  assign host_rdata = ch_h_rdata[sel_ch_q];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    lpc_mbx_channel #(
      .AW(AW), .EXT_DEPTH(EXT_DEPTH), .HAS_EXT(k == EXT_CH),
      .BASE_RST(BASE_RST[k*AW +: AW])
    ) u_ch (
      .clk     (bus_clk),
      .rst     (bus_rst),
      .h_we    (host_we && sel_ch_q == CH_W'(k)),
      .h_re    (host_re && sel_ch_q == CH_W'(k)),
      .h_off   (sel_off_q),
      .h_wdata (host_wdata),
      .h_rdata (ch_h_rdata[k]),
      .f_we    (fw_sel && fw_wr && f_ch == CH_W'(k)),
      .f_re    (fw_sel && !fw_wr && f_ch == CH_W'(k)),
      .f_off   (f_off),
      .f_wdata (fw_wdata),
      .f_rdata (ch_f_rdata[k]),
      .base    (ch_base[k])
    );
  end

  always_ff @(posedge bus_clk) begin
    if (bus_rst)               fw_rdata <= '0;
    else if (fw_sel && !fw_wr) fw_rdata <= ch_f_rdata[f_ch];
  end

  AST_FW_RDATA_HOLD: assert property (@(posedge bus_clk) disable iff (bus_rst)
    !(fw_sel && !fw_wr) |=> $stable(fw_rdata)); // R11

endmodule

// File: tb/sim_lpc_mailbox_target.sv
module sim_lpc_mailbox_target;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_n = 1'b1;
  logic [3:0] nib_in = 4'hF;
  logic [3:0] nib_out;
  logic       nib_oe;
  logic       fw_sel = 1'b0;
  logic       fw_wr = 1'b0;
  logic [6:0] fw_addr = '0;
  logic [7:0] fw_wdata = '0;
  logic [7:0] fw_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [15:0] m_base [4];
  logic [7:0]  m_idr [4];
  logic [7:0]  m_odr [4];
  bit          m_ibf [4];
  bit          m_obf [4];
  logic [7:0]  m_ext [16];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpc_mailbox_target u0 (
    .bus_clk (clk), .bus_rst (rst), .frame_n (frame_n),
    .nib_in (nib_in), .nib_out (nib_out), .nib_oe (nib_oe),
    .fw_sel (fw_sel), .fw_wr (fw_wr), .fw_addr (fw_addr),
    .fw_wdata (fw_wdata), .fw_rdata (fw_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_sts(input int ch);
    return {6'b0, m_ibf[ch], m_obf[ch]};
  endfunction

  function automatic bit ref_decode(input logic [15:0] a, output int ch, output int off);
    bit h;
    logic [15:0] d;
    h = 1'b0; ch = 0; off = 0;
    for (int k = 3; k >= 0; k--) begin
      d = a - m_base[k];
      if (d < 16'd2 || (k == 2 && d >= 16'd16 && d < 16'd32)) begin
        h = 1'b1; ch = k; off = int'(d);
      end
    end
    return h;
  endfunction

  task automatic drive(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frame_n = fr;
    nib_in  = nib;
  endtask

  task automatic host_io(input bit wr, input logic [3:0] ctype, input logic [15:0] addr,
                         input logic [7:0] wd, output logic [7:0] rd,
                         output bit responded, output bit shape_ok);
    logic [4:0] oe_s;
    logic [3:0] out_s [5];
    drive(1'b0, 4'h0);
    drive(1'b1, ctype);
    for (int i = 0; i < 4; i++) drive(1'b1, addr[15-4*i -: 4]);
    if (wr) begin
      drive(1'b1, wd[3:0]);
      drive(1'b1, wd[7:4]);
    end
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      oe_s[i]  = nib_oe;
      out_s[i] = nib_out;
    end
    responded = |oe_s;
    rd = {out_s[2], out_s[1]};
    if (wr) shape_ok = (oe_s == 5'b00001) && (out_s[0] == 4'h0);
    else    shape_ok = (oe_s == 5'b00111) && (out_s[0] == 4'h0);
  endtask

  task automatic fw_write(input int ch, input int off, input logic [7:0] d);
    @(negedge clk);
    fw_sel = 1'b1; fw_wr = 1'b1; fw_addr = {ch[1:0], off[4:0]}; fw_wdata = d;
    @(negedge clk);
    fw_sel = 1'b0; fw_wr = 1'b0;
    if (off == 1) begin m_odr[ch] = d; m_obf[ch] = 1'b1; end
    if (off == 3) m_base[ch][7:0]  = d;
    if (off == 4) m_base[ch][15:8] = d;
    if (ch == 2 && off >= 16) m_ext[off-16] = d;
  endtask

  task automatic fw_read(input int ch, input int off, output logic [7:0] d);
    @(negedge clk);
    fw_sel = 1'b1; fw_wr = 1'b0; fw_addr = {ch[1:0], off[4:0]};
    @(negedge clk);
    fw_sel = 1'b0;
    d = fw_rdata;
  endtask

  // firmware read checked against the model, with side effects
  task automatic fw_read_chk(input int ch, input int off, input string req);
    logic [7:0] d, e;
    case (off)
      0: e = m_idr[ch];
      1: e = m_odr[ch];
      2: e = m_sts(ch);
      3: e = m_base[ch][7:0];
      4: e = m_base[ch][15:8];
      default: e = (ch == 2) ? m_ext[off-16] : 8'h00;
    endcase
    fw_read(ch, off, d);
    check(req, {8'h0, d}, {8'h0, e});
    if (off == 0) m_ibf[ch] = 1'b0;
  endtask

  task automatic host_wr_chk(input logic [15:0] addr, input logic [7:0] wd, input string req);
    logic [7:0] rd;
    bit resp, shape, h;
    int ch, off;
    h = ref_decode(addr, ch, off);
    host_io(1'b1, 4'h2, addr, wd, rd, resp, shape);
    check(req, {15'b0, resp}, {15'b0, h});
    if (h) begin
      check(req, {15'b0, shape}, 16'h1);
      if (off == 0) begin m_idr[ch] = wd; m_ibf[ch] = 1'b1; end
      if (off >= 16) m_ext[off-16] = wd;
    end
  endtask

  task automatic host_rd_chk(input logic [15:0] addr, input string req);
    logic [7:0] rd, e;
    bit resp, shape, h;
    int ch, off;
    h = ref_decode(addr, ch, off);
    e = 8'h00;
    if (h) begin
      if (off == 0)      e = m_odr[ch];
      else if (off == 1) e = m_sts(ch);
      else               e = m_ext[off-16];
    end
    host_io(1'b0, 4'h0, addr, 8'h00, rd, resp, shape);
    check(req, {15'b0, resp}, {15'b0, h});
    if (h) begin
      check(req, {15'b0, shape}, 16'h1);
      check(req, {8'h0, rd}, {8'h0, e});
      if (off == 0) m_obf[ch] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hold;
    logic [7:0] rd;
    bit resp, shape;
    int unsigned seed_init;
    seed_init = $urandom(32'd1357);
    m_base[0] = 16'h0CA0; m_base[1] = 16'h0CA8; m_base[2] = 16'h0D00; m_base[3] = 16'h0CB0;
    for (int k = 0; k < 4; k++) begin
      m_idr[k] = 8'h00; m_odr[k] = 8'h00; m_ibf[k] = 1'b0; m_obf[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 oe", {15'b0, nib_oe}, 16'h0);
    for (int k = 0; k < 4; k++) begin
      fw_read_chk(k, 2, "R1 status");
      fw_read_chk(k, 3, "R1 base lo");
      fw_read_chk(k, 4, "R1 base hi");
    end

    for (int i = 0; i < 16; i++) fw_write(2, 16 + i, 8'(i * 17 + 3));

    // R2/R7: host write then firmware handshake
    host_wr_chk(16'h0CA0, 8'h5A, "R2 write cycle");
    fw_read_chk(0, 2, "R7 ibf set");
    fw_read_chk(0, 0, "R7 idr value");
    fw_read_chk(0, 2, "R7 ibf cleared");

    // R11: read data held while idle
    hold = fw_rdata;
    repeat (3) @(negedge clk);
    check("R11 rdata hold", {8'h0, fw_rdata}, {8'h0, hold});

    // R8/R3: firmware to host
    fw_write(1, 1, 8'hC3);
    host_rd_chk(16'h0CA9, "R8 status obf");
    host_rd_chk(16'h0CA8, "R3 read cycle");
    host_rd_chk(16'h0CA9, "R8 obf cleared");

    // R12: write to status offset is inert
    host_wr_chk(16'h0CA1, 8'hFF, "R12 status write");
    fw_read_chk(0, 0, "R12 idr unchanged");
    fw_read_chk(0, 2, "R12 status unchanged");

    // R5: foreign cycle type
    host_io(1'b1, 4'h4, 16'h0CA0, 8'h11, rd, resp, shape);
    check("R5 no drive", {15'b0, resp}, 16'h0);
    fw_read_chk(0, 0, "R5 idr unchanged");
    fw_read_chk(0, 2, "R5 status unchanged");

    // R6: unclaimed address
    host_wr_chk(16'h4321, 8'h66, "R6 write miss");
    host_rd_chk(16'h4321, "R6 read miss");
    for (int k = 0; k < 4; k++) fw_read_chk(k, 2, "R6 status unchanged");

    // R10: shared window
    host_wr_chk(16'h0D13, 8'h77, "R10 host ext write");
    fw_read_chk(2, 19, "R10 fw ext read");
    fw_write(2, 31, 8'h99);
    host_rd_chk(16'h0D1F, "R10 host ext read");
    host_rd_chk(16'h0CB8, "R10 no window on ch1");

    // R9: base moves and priority
    fw_write(3, 3, 8'h00);
    fw_write(3, 4, 8'h20);
    host_wr_chk(16'h2000, 8'h3C, "R9 moved base");
    fw_read_chk(3, 0, "R9 moved base idr");
    fw_write(1, 3, 8'hA0);
    host_wr_chk(16'h0CA0, 8'h44, "R9 overlap");
    fw_read_chk(0, 0, "R9 lowest wins");
    fw_read_chk(1, 2, "R9 loser untouched");
    fw_write(1, 3, 8'hA8);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int ch, sel, op;
      logic [15:0] a;
      ch  = int'($urandom % 4);
      sel = int'($urandom % 4);
      op  = int'($urandom % 5);
      case (sel)
        0: a = m_base[ch];
        1: a = m_base[ch] + 16'd1;
        2: a = (ch == 2) ? m_base[2] + 16'd16 + 16'($urandom % 16) : m_base[ch];
        default: a = 16'h4000 | 16'($urandom % 4096);
      endcase
      case (op)
        0: host_wr_chk(a, 8'($urandom), "R7 random host write");
        1: host_rd_chk(a, "R8 random host read");
        2: fw_write(ch, 1, 8'($urandom));
        3: fw_read_chk(ch, 0, "R7 random fw idr");
        default: fw_read_chk(ch, 2, "R8 random fw status");
      endcase
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule